// File: doc/BRIEF.md
# Banked External Interrupt Aggregator

This block gathers peripheral interrupt lines into banks of 32 and steers each line onto one of a small set of core trigger outputs. Every bank holds three registers: a sense register that picks edge or level behaviour per line, a mask register that admits or blocks each line, and a status register that shows which lines are pending. Every line also owns a vector register naming the trigger it drives. A vector of zero leaves the line unrouted.

Software reaches all registers through a plain register bus with separate read and write strobes. Writing a 1 to a status bit flips it, so one write path serves both to clear a captured edge and to raise a line again by hand. Each trigger output is the OR of every line that is pending, admitted by its mask bit and vectored to that trigger. Every input line passes through a two-stage synchroniser before any other logic sees it.

Top module: `ext_irq_aggregator`

## Requirements
- R1: After reset every status, sense, mask and vector register reads 0 (all lines edge sensitive) and every trigger output is low.
- R2: The register offsets for bank b are: status at 0x000 + 8*b, sense at 0x040 + 8*b, mask at 0x080 + 8*b. The vector of line n (bank b = n >> 5, offset o = n & 31) is at 0x1000*(b+1) + 4*o. Read data appears on `rd_data` in the cycle after `rd_en`. A read of an unmapped address, including a vector block beyond the last bank, returns 0.
- R3: A sense bit of 1 makes its line level sensitive. A sense bit of 0 makes it edge sensitive.
- R4: On an edge line, a synchronised 0-to-1 input transition sets the status bit. The bit stays set after the input falls.
- R5: Writing 1 to a status bit inverts it. Writing 0 leaves it unchanged. A clear followed by a second 1-write sets the bit again and retriggers the line.
- R6: On a level line, the status bit reads as the synchronised input OR a software-forced bit. Writing 1 to the status bit toggles that forced bit.
- R7: A mask bit of 0 keeps its line off every trigger output. The status bit still reads back while the line is masked.
- R8: Trigger output bit k-1 carries trigger index k. A line with vector 0, or with a vector above NUM_TRIG, drives no trigger.
- R9: A trigger output is high exactly when at least one line is pending, unmasked and vectored to it. It stays high while any such line remains.
- R10: If a status clear-write and a captured input edge on the same edge line fall in the same cycle, the status bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_BANKS*32 | Raw peripheral interrupt lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 16 | Byte address of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| trig_out | output | NUM_TRIG | Core trigger outputs; bit k-1 is trigger index k |

## Verification
Two events can land on the same status bit in one cycle: a software write that flips the bit, and a synchronised input edge that sets it. The bench counts the synchroniser and edge-detect stages so that its status write is active on exactly the clock edge that captures a new input rise. It does this twice: once with the bit already pending, where the write alone would clear it, and once with the bit idle. In both cases the bit must read back as set, because the edge must not be lost.

// File: rtl/agg_pkg.sv
package agg_pkg;
    localparam int unsigned LINES_PER_BANK = 32;
    localparam int unsigned BANK_STRIDE    = 8;
    localparam logic [15:0] STAT_BASE      = 16'h0000;
    localparam logic [15:0] SENSE_BASE     = 16'h0040;
    localparam logic [15:0] MASK_BASE      = 16'h0080;

    typedef struct packed {
        logic       hit;
        logic [6:0] line;
    } vec_hit_t;

    // Vector space: block b+1 of 4 KiB holds bank b, one word per line.
    function automatic vec_hit_t vec_decode(input logic [15:0] a, input int unsigned nbanks);
        vec_hit_t   r;
        logic [3:0] blk;
        blk    = a[15:12] - 4'd1;
        r.hit  = (a[15:12] != 4'd0) && (32'(a[15:12]) <= nbanks)
                 && (a[11:7] == 5'd0) && (a[1:0] == 2'd0);
        r.line = {blk[1:0], a[6:2]};
        return r;
    endfunction
endpackage

// File: rtl/agg_sync.sv
module agg_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.meta   = raw_i;
        sy_d.stable = sy_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign sync_o = sy_q.stable;
endmodule

// File: rtl/agg_bank.sv
module agg_bank
    import agg_pkg::*;
#(
    parameter int unsigned BANK_IDX = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] lvl_i,
    input  logic        wr_en,
    input  logic [15:0] addr,
    input  logic [31:0] wr_data,
    output logic [31:0] status_o,
    output logic [31:0] sense_o,
    output logic [31:0] mask_o
);
    localparam logic [15:0] MY_STAT  = STAT_BASE  + 16'(BANK_IDX * BANK_STRIDE);
    localparam logic [15:0] MY_SENSE = SENSE_BASE + 16'(BANK_IDX * BANK_STRIDE);
    localparam logic [15:0] MY_MASK  = MASK_BASE  + 16'(BANK_IDX * BANK_STRIDE);

    typedef struct packed {
        logic [31:0] sense;
        logic [31:0] mask;
        logic [31:0] pend;
        logic [31:0] prev;
    } bank_t;

    bank_t       bk_d, bk_q;
    logic [31:0] tog;
    logic [31:0] rise;

    always_comb begin
        bk_d      = bk_q;
        tog       = (wr_en && addr == MY_STAT) ? wr_data : 32'd0;
        rise      = lvl_i & ~bk_q.prev;
        bk_d.prev = lvl_i;
        bk_d.pend = (bk_q.pend ^ tog) | (rise & ~bk_q.sense);
        if (wr_en && addr == MY_SENSE) bk_d.sense = wr_data;
        if (wr_en && addr == MY_MASK)  bk_d.mask  = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign status_o = bk_q.pend | (lvl_i & bk_q.sense);
    assign sense_o  = bk_q.sense;
    assign mask_o   = bk_q.mask;

    // R4
    edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rise & ~bk_q.sense)) |=>
        ((bk_q.pend & $past(rise & ~bk_q.sense)) == $past(rise & ~bk_q.sense)));

    // R5
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tog == 32'd0) |=> (($past(bk_q.pend) & ~bk_q.pend) == 32'd0));

    // R5
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tog != 32'd0) |=>
        (((bk_q.pend ^ $past(bk_q.pend)) & $past(tog & ~rise)) == $past(tog & ~rise)));
endmodule

// File: rtl/agg_route.sv
module agg_route
    import agg_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned NUM_TRIG  = 4,
    parameter int unsigned NUM_LINES = NUM_BANKS * LINES_PER_BANK,
    parameter int unsigned VEC_W     = $clog2(NUM_TRIG + 1),
    parameter int unsigned LINE_W    = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [15:0]          addr,
    input  logic [31:0]          wr_data,
    input  logic [NUM_LINES-1:0] active_i,
    input  logic [LINE_W-1:0]    rd_line_i,
    output logic [VEC_W-1:0]     vec_rd_o,
    output logic [NUM_TRIG-1:0]  trig_o
);
    typedef struct packed {
        logic [NUM_LINES-1:0][VEC_W-1:0] vec;
    } route_t;

    route_t   rt_d, rt_q;
    vec_hit_t wdec;

    always_comb begin
        rt_d = rt_q;
        wdec = vec_decode(addr, NUM_BANKS);
        if (wr_en && wdec.hit)
            rt_d.vec[LINE_W'(wdec.line)] = wr_data[VEC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rt_q <= '0;
        else        rt_q <= rt_d;
    end

    for (genvar k = 1; k <= NUM_TRIG; k++) begin : g_trig
        always_comb begin
            trig_o[k-1] = 1'b0;
            for (int l = 0; l < NUM_LINES; l++)
                if (active_i[l] && rt_q.vec[l] == VEC_W'(k)) trig_o[k-1] = 1'b1;
        end
    end

    assign vec_rd_o = rt_q.vec[rd_line_i];

    // R9
    trig_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o != '0) |-> (active_i != '0));
endmodule

// File: rtl/ext_irq_aggregator.sv
module ext_irq_aggregator
    import agg_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned NUM_TRIG  = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_BANKS*LINES_PER_BANK-1:0] irq_in,
    input  logic                               wr_en,
    input  logic                               rd_en,
    input  logic [15:0]                        addr,
    input  logic [31:0]                        wr_data,
    output logic [31:0]                        rd_data,
    output logic [NUM_TRIG-1:0]                trig_out
);
    localparam int unsigned NUM_LINES = NUM_BANKS * LINES_PER_BANK;
    localparam int unsigned VEC_W     = $clog2(NUM_TRIG + 1);
    localparam int unsigned LINE_W    = $clog2(NUM_LINES);

    logic [NUM_LINES-1:0] lvl;
    logic [NUM_LINES-1:0] status_all, sense_all, mask_all;
    logic [VEC_W-1:0]     vec_rd;
    vec_hit_t             rdec;

    typedef struct packed {
        logic [31:0] data;
    } rd_t;

    rd_t rd_d, rd_q;

    agg_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(irq_in), .sync_o(lvl)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        agg_bank #(.BANK_IDX(b)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl_i    (lvl[b*32 +: 32]),
            .wr_en    (wr_en),
            .addr     (addr),
            .wr_data  (wr_data),
            .status_o (status_all[b*32 +: 32]),
            .sense_o  (sense_all[b*32 +: 32]),
            .mask_o   (mask_all[b*32 +: 32])
        );
    end

    always_comb rdec = vec_decode(addr, NUM_BANKS);

    agg_route #(.NUM_BANKS(NUM_BANKS), .NUM_TRIG(NUM_TRIG)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .active_i  (status_all & mask_all),
        .rd_line_i (LINE_W'(rdec.line)),
        .vec_rd_o  (vec_rd),
        .trig_o    (trig_out)
    );

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d.data = 32'd0;
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (addr == STAT_BASE  + 16'(b * BANK_STRIDE)) rd_d.data = status_all[b*32 +: 32];
                if (addr == SENSE_BASE + 16'(b * BANK_STRIDE)) rd_d.data = sense_all[b*32 +: 32];
                if (addr == MASK_BASE  + 16'(b * BANK_STRIDE)) rd_d.data = mask_all[b*32 +: 32];
            end
            if (rdec.hit) rd_d.data = 32'(vec_rd);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q.data;

    // R7
    all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_all == '0) |-> (trig_out == '0));
endmodule

// File: tb/sim_ext_irq_aggregator.sv
module sim_ext_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  trig_out;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    ext_irq_aggregator #(.NUM_BANKS(2), .NUM_TRIG(4)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .trig_out(trig_out)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(16'h0000, d); chk("R1 status", d, 0);
        rd(16'h0048, d); chk("R1 sense", d, 0);
        rd(16'h0088, d); chk("R1 mask", d, 0);
        rd(16'h1000, d); chk("R1 vector", d, 0);
        chk("R1 trig", 32'(trig_out), 0);
    endtask

    task automatic t_addr();
        logic [31:0] d;
        wr(16'h0048, 32'hA5A5_0000); rd(16'h0048, d); chk("R2 sense bank1", d, 32'hA5A5_0000);
        rd(16'h0040, d); chk("R2 sense bank0 untouched", d, 0);
        wr(16'h0048, 32'h0);
        wr(16'h2014, 32'd3); rd(16'h2014, d); chk("R2 vector line37", d, 3);
        rd(16'h1014, d); chk("R2 vector line5 untouched", d, 0);
        rd(16'h0004, d); chk("R2 unmapped", d, 0);
        rd(16'h3000, d); chk("R2 vector beyond banks", d, 0);
        wr(16'h2014, 32'd0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        @(negedge clk); irq_in[3] = 1'b1; idle(4);
        rd(16'h0000, d); chk("R4 edge captured", d, 32'h8);
        irq_in[3] = 1'b0; idle(4);
        rd(16'h0000, d); chk("R4 sticky after fall", d, 32'h8);
        wr(16'h0000, 32'h0); rd(16'h0000, d); chk("R5 write 0 no effect", d, 32'h8);
        wr(16'h0000, 32'h8); rd(16'h0000, d); chk("R5 toggle clears", d, 0);
        wr(16'h0000, 32'h8); rd(16'h0000, d); chk("R5 retrigger", d, 32'h8);
        wr(16'h0000, 32'h8);
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(16'h0040, 32'h400);
        wr(16'h1028, 32'd1); wr(16'h0080, 32'h400);
        @(negedge clk); irq_in[10] = 1'b1; idle(3);
        rd(16'h0000, d); chk("R3 level follows input", d, 32'h400);
        chk("R6 level drives trig1", 32'(trig_out), 32'h1);
        irq_in[10] = 1'b0; idle(3);
        rd(16'h0000, d); chk("R3 level not sticky", d, 0);
        wr(16'h0000, 32'h400); rd(16'h0000, d); chk("R6 forced", d, 32'h400);
        wr(16'h0000, 32'h400); rd(16'h0000, d); chk("R6 force removed", d, 0);
        wr(16'h0080, 32'h0); wr(16'h1028, 32'd0); wr(16'h0040, 32'h0);
    endtask

    task automatic t_route();
        logic [31:0] d;
        wr(16'h2014, 32'd2);
        wr(16'h0008, 32'h20);
        idle(1); chk("R7 masked blocks trig", 32'(trig_out), 0);
        rd(16'h0008, d); chk("R7 status visible while masked", d, 32'h20);
        wr(16'h0088, 32'h20); idle(1); chk("R8 vector 2 -> bit1", 32'(trig_out), 32'h2);
        wr(16'h2014, 32'd0); idle(1); chk("R8 vector 0 unrouted", 32'(trig_out), 0);
        wr(16'h2014, 32'd5); idle(1); chk("R8 vector above range", 32'(trig_out), 0);
        wr(16'h2014, 32'd4); idle(1); chk("R8 vector 4 -> bit3", 32'(trig_out), 32'h8);
        wr(16'h1008, 32'd4); wr(16'h0080, 32'h4); wr(16'h0000, 32'h4);
        wr(16'h0008, 32'h20); idle(1); chk("R9 OR of remaining line", 32'(trig_out), 32'h8);
        wr(16'h0000, 32'h4); idle(1); chk("R9 none pending", 32'(trig_out), 0);
        wr(16'h0088, 32'h0); wr(16'h0080, 32'h0);
    endtask

    task automatic t_collide(input logic preset, input string tag);
        logic [31:0] d;
        if (preset) wr(16'h0000, 32'h2);
        @(negedge clk); irq_in[1] = 1'b1;
        @(negedge clk); @(negedge clk);
        wr_en = 1'b1; addr = 16'h0000; wr_data = 32'h2;
        @(negedge clk); wr_en = 1'b0;
        rd(16'h0000, d); chk(tag, d, 32'h2);
        irq_in[1] = 1'b0; idle(3);
        wr(16'h0000, 32'h2);
    endtask

    initial begin
        idle(3); rst_n = 1'b1; idle(2);
        t_reset();
        t_addr();
        t_edge();
        t_level();
        t_route();
        t_collide(1'b1, "R10 clear vs edge, pending");
        t_collide(1'b0, "R10 set vs edge, idle");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule